// File: doc/BRIEF.md
# SIMD Lane Permute Unit

This block rearranges the lanes of one or two 64-bit operands. It covers six kinds of operation:

- interleaving the lower or upper half of two operands;
- widening half of one operand, with zero or sign extension;
- truncating pack of two operands into narrower lanes;
- halfword shuffle steered by an 8-bit selector;
- byte-granular extraction from the concatenation of two operands;
- scalar broadcast.

Alongside the 64-bit result it returns a 32-bit flag word. For every lane of the result, the flag word carries a negative bit (the lane's top bit) and a zero bit (the lane is all zeros). Where these bits sit depends on the lane width of the result.

An operation is issued by raising `op_vld` for one cycle together with the opcode, the size, the immediate and the operands. The result is registered. A two-state phase machine drives the result-valid pulse:

- **PH_IDLE**: nothing new is presented.
- **PH_RESULT**: a result captured at the last edge is being presented.

There are two transitions:

- **ISSUE**: taken from either state when `op_vld` is high; the next state is PH_RESULT.
- **DRAIN**: taken from either state when `op_vld` is low; the next state is PH_IDLE.

When no operation is issued, the output registers keep their last value.

Opcode encoding on `op_code`:

| Code | Operation |
|------|-----------|
| 0 | low interleave |
| 1 | high interleave |
| 2 | low widen |
| 3 | high widen |
| 4 | pack |
| 5 | shuffle |
| 6 | align |
| 7 | broadcast |

Size encoding on `op_size`:

| Code | Lane width |
|------|------------|
| 0 | byte |
| 1 | halfword |
| 2 | word |
| 3 | treated as word |

Top module: `simd_permute_unit`

## Requirements
- R1: While `rst_n` is low, and after reset until the first issue, `res_vld`, `res_data` and `res_flags` are all zero.
- R2: A result issued with `op_vld` high at a rising edge appears on `res_data` and `res_flags` after that edge, and `res_vld` is high for exactly that cycle. Without `op_vld`, `res_vld` is low and both outputs hold their value.
- R3: Interleave (op 0 low, op 1 high), with element width W given by the size: result element 2k takes element k+o of a, and result element 2k+1 takes element k+o of b. Here o is 0 for the low form and half the element count for the high form.
- R4: Widen (op 2 low, op 3 high) turns the lower or upper half of a into lanes of twice the width W. The extension is sign extension when `op_imm[0]`=1 and zero extension otherwise.
- R5: Pack (op 4) with result width W takes the low W bits of each 2W-bit lane. The lanes of a fill the lower 32 result bits and the lanes of b fill the upper 32, each in lane order. No saturation is applied.
- R6: Shuffle (op 5) sets result halfword j to the halfword of a selected by `op_imm[2j+1:2j]`.
- R7: Align (op 6), with n = `op_imm[2:0]`, returns bits [8n+63:8n] of the 128-bit value {b,a}. For n=0 this is a.
- R8: Broadcast (op 7) replicates the low W bits of a across all 64 result bits.
- R9: Flag positions depend on the flag lane width:
  - byte lane i: N at bit 4i+3, Z at bit 4i+2;
  - halfword lane h: N at bit 8h+7, Z at bit 8h+6;
  - word lane w: N at bit 16w+15, Z at bit 16w+14;
  - full 64-bit value: N at bit 31, Z at bit 30.
  All other flag bits are zero.
- R10: The flag lane width is the result lane width:
  - interleave, pack and broadcast use the size;
  - widen uses twice the size (64 bits for word);
  - shuffle uses halfword;
  - align uses the full 64-bit value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_vld | input | 1 | Issue strobe |
| op_code | input | 3 | Operation select |
| op_size | input | 2 | Element size select |
| op_imm | input | 8 | Selector, byte count or extension select |
| opnd_a | input | 64 | First operand |
| opnd_b | input | 64 | Second operand |
| res_vld | output | 1 | Result valid this cycle |
| res_data | output | 64 | Permuted result |
| res_flags | output | 32 | Per-lane negative and zero flags |

## Verification
Every result and its flag word are due exactly one rising edge after the issuing edge. `res_vld` is high only during the cycle that follows. The bench drives each operation on a falling edge and samples at the next falling edge, which is half a period after the capturing edge. It then drops `op_vld` and samples once more at the following falling edge to confirm the hold behaviour.

// File: rtl/simd_perm_pkg.sv
package simd_perm_pkg;
    localparam int DW   = 64;
    localparam int FW   = DW / 2;
    localparam int OPW  = 3;
    localparam int SZW  = 2;
    localparam int IMMW = 8;
    localparam int NBYTE = DW / 8;
    localparam int NHALF = DW / 16;
    localparam int NWORD = DW / 32;

    typedef logic [DW-1:0] vec_t;
    typedef logic [FW-1:0] flag_t;

    typedef enum logic [OPW-1:0] {
        OP_MIX_LO   = 3'd0,
        OP_MIX_HI   = 3'd1,
        OP_WIDEN_LO = 3'd2,
        OP_WIDEN_HI = 3'd3,
        OP_NARROW   = 3'd4,
        OP_SHUF     = 3'd5,
        OP_ALIGN    = 3'd6,
        OP_BCAST    = 3'd7
    } perm_op_e;

    typedef enum logic [SZW-1:0] {
        SZ_B = 2'd0,
        SZ_H = 2'd1,
        SZ_W = 2'd2,
        SZ_D = 2'd3
    } lane_sz_e;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_RESULT = 1'b1
    } phase_e;
endpackage

// File: rtl/simd_perm_datapath.sv
module simd_perm_datapath
    import simd_perm_pkg::*;
(
    input  perm_op_e            op,
    input  lane_sz_e            sz,
    input  logic [IMMW-1:0]     imm,
    input  vec_t                a,
    input  vec_t                b,
    output vec_t                res,
    output lane_sz_e            flag_sz
);
    localparam int HALF_BYTES = NBYTE / 2;
    localparam int HALF_HALFS = NHALF / 2;
    localparam int HALF_WORDS = NWORD / 2;

    vec_t mix_v, widen_v, narrow_v, shuf_v, align_v, bcast_v;
    logic hi_sel;
    logic sext;
    logic [2*DW-1:0] cat;

    assign hi_sel = (op == OP_MIX_HI) || (op == OP_WIDEN_HI);
    assign sext   = imm[0];
    assign cat    = {b, a};

    // interleave of two operands
    always_comb begin
        mix_v = '0;
        case (sz)
            SZ_B: begin
                for (int k = 0; k < HALF_BYTES; k++) begin
                    mix_v[16*k   +: 8] = a[8*(k + (hi_sel ? HALF_BYTES : 0)) +: 8];
                    mix_v[16*k+8 +: 8] = b[8*(k + (hi_sel ? HALF_BYTES : 0)) +: 8];
                end
            end
            SZ_H: begin
                for (int k = 0; k < HALF_HALFS; k++) begin
                    mix_v[32*k    +: 16] = a[16*(k + (hi_sel ? HALF_HALFS : 0)) +: 16];
                    mix_v[32*k+16 +: 16] = b[16*(k + (hi_sel ? HALF_HALFS : 0)) +: 16];
                end
            end
            default: begin
                for (int k = 0; k < HALF_WORDS; k++) begin
                    mix_v[64*k    +: 32] = a[32*(k + (hi_sel ? HALF_WORDS : 0)) +: 32];
                    mix_v[64*k+32 +: 32] = b[32*(k + (hi_sel ? HALF_WORDS : 0)) +: 32];
                end
            end
        endcase
    end

    // single operand widening
    always_comb begin
        widen_v = '0;
        case (sz)
            SZ_B: begin
                for (int k = 0; k < HALF_BYTES; k++) begin
                    widen_v[16*k +: 16] =
                        {{8{sext & a[8*(k + (hi_sel ? HALF_BYTES : 0)) + 7]}},
                         a[8*(k + (hi_sel ? HALF_BYTES : 0)) +: 8]};
                end
            end
            SZ_H: begin
                for (int k = 0; k < HALF_HALFS; k++) begin
                    widen_v[32*k +: 32] =
                        {{16{sext & a[16*(k + (hi_sel ? HALF_HALFS : 0)) + 15]}},
                         a[16*(k + (hi_sel ? HALF_HALFS : 0)) +: 16]};
                end
            end
            default: begin
                for (int k = 0; k < HALF_WORDS; k++) begin
                    widen_v[64*k +: 64] =
                        {{32{sext & a[32*(k + (hi_sel ? HALF_WORDS : 0)) + 31]}},
                         a[32*(k + (hi_sel ? HALF_WORDS : 0)) +: 32]};
                end
            end
        endcase
    end

    // truncating pack
    always_comb begin
        narrow_v = '0;
        case (sz)
            SZ_B: begin
                for (int k = 0; k < NHALF; k++) begin
                    narrow_v[8*k         +: 8] = a[16*k +: 8];
                    narrow_v[8*(k+NHALF) +: 8] = b[16*k +: 8];
                end
            end
            SZ_H: begin
                for (int k = 0; k < NWORD; k++) begin
                    narrow_v[16*k         +: 16] = a[32*k +: 16];
                    narrow_v[16*(k+NWORD) +: 16] = b[32*k +: 16];
                end
            end
            default: begin
                narrow_v = {b[31:0], a[31:0]};
            end
        endcase
    end

    // halfword shuffle
    always_comb begin
        shuf_v = '0;
        for (int j = 0; j < NHALF; j++) begin
            shuf_v[16*j +: 16] = a[16*imm[2*j +: 2] +: 16];
        end
    end

    // byte align and broadcast
    always_comb begin
        align_v = cat[8*imm[2:0] +: DW];
        case (sz)
            SZ_B:    bcast_v = {NBYTE{a[7:0]}};
            SZ_H:    bcast_v = {NHALF{a[15:0]}};
            default: bcast_v = {NWORD{a[31:0]}};
        endcase
    end

    // result and flag width select
    always_comb begin
        case (op)
            OP_MIX_LO, OP_MIX_HI: begin
                res     = mix_v;
                flag_sz = sz;
            end
            OP_WIDEN_LO, OP_WIDEN_HI: begin
                res     = widen_v;
                flag_sz = (sz == SZ_B) ? SZ_H : ((sz == SZ_H) ? SZ_W : SZ_D);
            end
            OP_NARROW: begin
                res     = narrow_v;
                flag_sz = sz;
            end
            OP_SHUF: begin
                res     = shuf_v;
                flag_sz = SZ_H;
            end
            OP_ALIGN: begin
                res     = align_v;
                flag_sz = SZ_D;
            end
            default: begin
                res     = bcast_v;
                flag_sz = sz;
            end
        endcase
    end
endmodule

// File: rtl/simd_lane_flags.sv
module simd_lane_flags
    import simd_perm_pkg::*;
(
    input  vec_t     val,
    input  lane_sz_e sz,
    output flag_t    flags
);
    flag_t fb, fh, fw, fd;

    generate
        for (genvar i = 0; i < NBYTE; i++) begin : g_byte
            assign fb[4*i+3]   = val[8*i+7];
            assign fb[4*i+2]   = ~|val[8*i +: 8];
            assign fb[4*i +: 2] = 2'b00;
        end
        for (genvar h = 0; h < NHALF; h++) begin : g_half
            assign fh[8*h+7]    = val[16*h+15];
            assign fh[8*h+6]    = ~|val[16*h +: 16];
            assign fh[8*h +: 6] = 6'b0;
        end
        for (genvar w = 0; w < NWORD; w++) begin : g_word
            assign fw[16*w+15]    = val[32*w+31];
            assign fw[16*w+14]    = ~|val[32*w +: 32];
            assign fw[16*w +: 14] = 14'b0;
        end
    endgenerate

    assign fd = {val[DW-1], ~|val, {(FW-2){1'b0}}};

    always_comb begin
        case (sz)
            SZ_B:    flags = fb;
            SZ_H:    flags = fh;
            SZ_W:    flags = fw;
            default: flags = fd;
        endcase
    end
endmodule

// File: rtl/simd_permute_unit.sv
module simd_permute_unit
    import simd_perm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_vld,
    input  logic [OPW-1:0]   op_code,
    input  logic [SZW-1:0]   op_size,
    input  logic [IMMW-1:0]  op_imm,
    input  logic [DW-1:0]    opnd_a,
    input  logic [DW-1:0]    opnd_b,
    output logic             res_vld,
    output logic [DW-1:0]    res_data,
    output logic [FW-1:0]    res_flags
);
    phase_e   phase_q, phase_d;
    lane_sz_e sz_n;
    lane_sz_e flag_sz;
    vec_t     dp_res;
    flag_t    dp_flags;
    vec_t     res_q;
    flag_t    flags_q;

    assign sz_n = (op_size == 2'd3) ? SZ_W : lane_sz_e'(op_size);

    simd_perm_datapath i_dp (
        .op      (perm_op_e'(op_code)),
        .sz      (sz_n),
        .imm     (op_imm),
        .a       (opnd_a),
        .b       (opnd_b),
        .res     (dp_res),
        .flag_sz (flag_sz)
    );

    simd_lane_flags i_flags (
        .val   (dp_res),
        .sz    (flag_sz),
        .flags (dp_flags)
    );

    // phase register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // transitions ISSUE and DRAIN
    always_comb begin
        unique case (phase_q)
            PH_IDLE:   phase_d = op_vld ? PH_RESULT : PH_IDLE;
            PH_RESULT: phase_d = op_vld ? PH_RESULT : PH_IDLE;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (op_vld) begin
            res_q   <= dp_res;
            flags_q <= dp_flags;
        end
    end

    assign res_vld   = (phase_q == PH_RESULT);
    assign res_data  = res_q;
    assign res_flags = flags_q;
endmodule

// File: rtl/simd_permute_chk.sv
module simd_permute_chk
    import simd_perm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             op_vld,
    input logic [OPW-1:0]   op_code,
    input logic [SZW-1:0]   op_size,
    input logic [IMMW-1:0]  op_imm,
    input logic [DW-1:0]    opnd_a,
    input logic [DW-1:0]    res_data,
    input logic [FW-1:0]    res_flags,
    input logic             res_vld
);
    // R2
    res_follows_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_vld |=> res_vld);
    // R2
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> !res_vld);
    // R2
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_vld |=> ($stable(res_data) && $stable(res_flags)));
    // R9
    flag_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_flags & 32'h3333_3333) == 32'h0);
    // R8
    bcast_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 3'(OP_BCAST) && op_size == 2'(SZ_B))
        |=> res_data == {8{$past(opnd_a[7:0])}});
    // R6
    shuf_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vld && op_code == 3'(OP_SHUF) && op_imm == 8'hE4)
        |=> res_data == $past(opnd_a));
endmodule

bind simd_permute_unit simd_permute_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_vld    (op_vld),
    .op_code   (op_code),
    .op_size   (op_size),
    .op_imm    (op_imm),
    .opnd_a    (opnd_a),
    .res_data  (res_data),
    .res_flags (res_flags),
    .res_vld   (res_vld)
);

// File: tb/test_simd_permute_unit.sv
`timescale 1ns/1ps
module test_simd_permute_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_vld = 1'b0;
    logic [2:0]  op_code = '0;
    logic [1:0]  op_size = '0;
    logic [7:0]  op_imm = '0;
    logic [63:0] opnd_a = '0;
    logic [63:0] opnd_b = '0;
    logic        res_vld;
    logic [63:0] res_data;
    logic [31:0] res_flags;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_permute_unit i_simd_permute_unit (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld), .op_code(op_code),
        .op_size(op_size), .op_imm(op_imm), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .res_vld(res_vld), .res_data(res_data), .res_flags(res_flags)
    );

    function automatic logic [63:0] lmask(int w);
        return (w >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] ref_res(int op, int sz, logic [7:0] imm,
                                            logic [63:0] a, logic [63:0] b);
        int w = 8 << sz;
        logic [63:0] m = lmask(w);
        logic [63:0] r = '0;
        logic [63:0] e;
        int n;
        case (op)
            0, 1: begin
                n = 32 / w;
                for (int k = 0; k < n; k++) begin
                    r |= ((a >> (w*(k + (op == 1 ? n : 0)))) & m) << (2*k*w);
                    r |= ((b >> (w*(k + (op == 1 ? n : 0)))) & m) << ((2*k+1)*w);
                end
            end
            2, 3: begin
                n = 32 / w;
                for (int k = 0; k < n; k++) begin
                    e = (a >> (w*(k + (op == 3 ? n : 0)))) & m;
                    if (imm[0] && e[w-1]) e = (e | ~m) & lmask(2*w);
                    r |= e << (k*2*w);
                end
            end
            4: begin
                n = 32 / w;
                for (int k = 0; k < n; k++) begin
                    r |= ((a >> (2*w*k)) & m) << (w*k);
                    r |= ((b >> (2*w*k)) & m) << (w*(k+n));
                end
            end
            5: begin
                for (int j = 0; j < 4; j++)
                    r |= ((a >> (16*((imm >> (2*j)) & 3))) & 64'hFFFF) << (16*j);
            end
            6: begin
                n = int'(imm[2:0]);
                r = (n == 0) ? a : ((a >> (8*n)) | (b << (64 - 8*n)));
            end
            default: begin
                for (int k = 0; k < 64 / w; k++) r |= (a & m) << (k*w);
            end
        endcase
        return r;
    endfunction

    function automatic int ref_fsz(int op, int sz);
        case (op)
            2, 3:    return sz + 1;
            5:       return 1;
            6:       return 3;
            default: return sz;
        endcase
    endfunction

    function automatic logic [31:0] ref_flags(int fsz, logic [63:0] r);
        logic [31:0] f = '0;
        int w = 8 << fsz;
        int step = 4 << fsz;
        logic [63:0] lane;
        if (fsz == 3) begin
            f[31] = r[63];
            f[30] = (r == 64'd0);
        end else begin
            for (int i = 0; i < 64 / w; i++) begin
                lane = (r >> (i*w)) & lmask(w);
                f[i*step + step - 1] = lane[w-1];
                f[i*step + step - 2] = (lane == 64'd0);
            end
        end
        return f;
    endfunction

    function automatic string op_tag(int op);
        case (op)
            0, 1:    return "R3";
            2, 3:    return "R4 R10";
            4:       return "R5";
            5:       return "R6";
            6:       return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(int op, int sz, logic [7:0] imm, logic [63:0] a, logic [63:0] b);
        logic [63:0] er;
        logic [31:0] ef;
        logic [63:0] held_r;
        er = ref_res(op, sz, imm, a, b);
        ef = ref_flags(ref_fsz(op, sz), er);
        @(negedge clk);
        op_vld = 1'b1; op_code = 3'(op); op_size = 2'(sz); op_imm = imm;
        opnd_a = a; opnd_b = b;
        @(negedge clk);
        op_vld = 1'b0;
        opnd_a = ~a; opnd_b = ~b;
        check64("R2 res_vld", {63'd0, res_vld}, 64'd1);
        check64(op_tag(op), res_data, er);
        check64("R9 R10 flags", {32'd0, res_flags}, {32'd0, ef});
        held_r = res_data;
        @(negedge clk);
        check64("R2 hold", res_data, held_r);
        check64("R2 idle", {63'd0, res_vld}, 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        logic [63:0] ra, rb;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1
        check64("R1 reset vld", {63'd0, res_vld}, 64'd0);
        check64("R1 reset data", res_data, 64'd0);
        check64("R1 reset flags", {32'd0, res_flags}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check64("R1 after reset", res_data, 64'd0);

        run_op(0, 0, 8'h00, 64'h8877_6655_4433_2211, 64'h0FEE_DDCC_BBAA_9900);
        run_op(1, 0, 8'h00, 64'h8877_6655_4433_2211, 64'h0FEE_DDCC_BBAA_9900);
        run_op(1, 2, 8'h00, 64'h8000_0000_1234_5678, 64'h0000_0000_FFFF_FFFF);
        run_op(2, 0, 8'h01, 64'h0000_0000_80FF_7F00, 64'd0);
        run_op(2, 0, 8'h00, 64'h0000_0000_80FF_7F00, 64'd0);
        run_op(3, 2, 8'h01, 64'h8000_0001_0000_0000, 64'd0);
        run_op(3, 1, 8'h01, 64'h0000_FFFF_0000_0000, 64'd0);
        run_op(4, 0, 8'h00, 64'h1180_2270_3360_4450, 64'hAA01_BB02_CC03_DD04);
        run_op(4, 1, 8'h00, 64'hDEAD_8000_BEEF_0000, 64'h1234_5678_9ABC_DEF0);
        run_op(5, 1, 8'h1B, 64'h4444_3333_2222_1111, 64'd0);
        run_op(5, 1, 8'hE4, 64'h8000_0000_FFFF_0001, 64'd0);
        run_op(6, 3, 8'h00, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        run_op(6, 3, 8'h07, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        run_op(6, 3, 8'h03, 64'h0, 64'h0);
        run_op(7, 0, 8'h00, 64'h0000_0000_0000_0080, 64'd0);
        run_op(7, 2, 8'h00, 64'h0000_0000_0000_0000, 64'd0);
        run_op(7, 1, 8'h00, 64'hFFFF_FFFF_FFFF_8001, 64'd0);

        for (int i = 0; i < 400; i++) begin
            ra = {$urandom(), $urandom()};
            rb = {$urandom(), $urandom()};
            if (i % 7 == 0) ra[31:0] = 32'd0;
            run_op(int'($urandom_range(0, 7)), int'($urandom_range(0, 2)),
                   8'($urandom()), ra, rb);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end
endmodule